// File: doc/BRIEF.md
# Decode-Time Branch Target Checker

This block sits at the decode stage of a pipelined processor and inspects a group of instruction slots that arrive in program order in one cycle. For each direct control transfer whose direction is already known at decode (it is unconditional, or it was predicted taken) it compares the target that decode computed against the target the front end predicted. It also catches an instruction that was predicted taken although it is not a control transfer at all.

The first slot that proves wrong becomes the squash point. Slots up to and including it go forward to the next stage, later slots do not, and every valid slot in the group with a larger sequence number is flagged as killed. One cycle later a registered redirect record carries the offender's sequence number, the correct next PC and the taken bit back to the front end. Forwarded slots with no source operands are marked ready to issue. Two saturating counters record how many branches were resolved and how many target mispredictions were found.

Top module: `br_target_check`

## Requirements
- R1: A slot is checked only when it is valid, a control transfer, direct, and either unconditional or predicted taken; a target difference in any other slot causes no redirect.
- R2: A checked slot whose computed target differs from its predicted target causes, on the next cycle, redir_valid=1, redir_squash=1, redir_mispred=1, redir_seq equal to that slot's sequence number and redir_pc equal to its computed target.
- R3: redir_taken is the offender's branching bit ORed with its unconditional bit.
- R4: fwd_valid carries the valid slots from slot 0 up to and including the first offending slot (bit i is slot i); all valid slots are forwarded when there is no offender.
- R5: slot_kill bit i is 1 for each valid slot whose sequence number is strictly greater than the offender's; it is all zero when there is no offender.
- R6: A valid slot predicted taken that is not a control transfer is an offender: the next cycle gives redir_valid=1, redir_squash=1, pred_fault=1, redir_mispred=0, redir_pc equal to its computed target field.
- R7: fwd_can_issue bit i is 1 exactly when slot i is forwarded and has its no-source bit set.
- R8: When several slots offend in one cycle, the lowest-index slot is the squash point.
- R9: After reset and in any cycle following a group with no offender, redir_valid, pred_fault, redir_seq and redir_pc are 0; each offending group yields a redirect valid for exactly one cycle.
- R10: cnt_resolved adds, each cycle, the number of checked slots that are forwarded, and holds at its all-ones maximum instead of wrapping.
- R11: cnt_mispred adds one for each cycle whose squash point is a target mismatch (not a fault) and holds at its all-ones maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_valid | input | SLOTS | Slot holds an instruction |
| slot_seq | input | SLOTS*SEQ_W | Sequence number per slot |
| slot_ctrl | input | SLOTS | Slot is a control transfer |
| slot_direct | input | SLOTS | Target is PC-relative/immediate |
| slot_uncond | input | SLOTS | Control transfer is unconditional |
| slot_pred_taken | input | SLOTS | Front end predicted taken |
| slot_branching | input | SLOTS | Branching status of the instruction |
| slot_no_src | input | SLOTS | Instruction reads no source register |
| slot_pred_tgt | input | SLOTS*PC_W | Predicted target per slot |
| slot_calc_tgt | input | SLOTS*PC_W | Decode-computed direct target per slot |
| fwd_valid | output | SLOTS | Slots passed to the next stage |
| fwd_can_issue | output | SLOTS | Forwarded slots ready to issue |
| slot_kill | output | SLOTS | Slots younger than the squash point |
| redir_valid | output | 1 | Redirect record valid |
| redir_squash | output | 1 | Squash request |
| redir_mispred | output | 1 | Squash point was a target mismatch |
| redir_seq | output | SEQ_W | Sequence number of the squash point |
| redir_pc | output | PC_W | Correct next PC |
| redir_taken | output | 1 | Taken bit for the redirect |
| pred_fault | output | 1 | Non-control predicted taken |
| cnt_resolved | output | CNT_W | Saturating resolved-branch count |
| cnt_mispred | output | CNT_W | Saturating mispredict count |

## Verification
The bench builds the block with four slots, 16-bit sequence numbers, 32-bit PCs and 3-bit counters. Four slots let a group hold an offender with both older and younger neighbours and a second, later offender, so priority and the kill/forward split are visible. The 3-bit counters top out at 7, which a handful of cycles reaches, so the saturation rule for both counters is exercised rather than left to width.

// File: rtl/brc_pkg.sv
// Shared types for the decode-time branch target checker.
package brc_pkg;
    // Flags carried by a registered redirect record.
    typedef struct packed {
        logic valid;
        logic mispred;
        logic taken;
        logic fault;
    } redir_flags_t;
endpackage

// File: rtl/brc_slot_eval.sv
// Per-slot classification: decides whether a slot is checked, whether its
// predicted target disagrees with the computed one, and whether it is a
// non-control instruction that was predicted taken.
// Assumes targets are already computed upstream.
module brc_slot_eval #(
    parameter int PC_W = 32
) (
    input  logic            valid,
    input  logic            is_ctrl,
    input  logic            is_direct,
    input  logic            is_uncond,
    input  logic            pred_taken,
    input  logic [PC_W-1:0] pred_tgt,
    input  logic [PC_W-1:0] calc_tgt,
    output logic            checked,
    output logic            bad_tgt,
    output logic            bad_ctrl
);
    // Classify the slot from its flags and targets.
    always_comb begin
        checked  = valid && is_ctrl && is_direct && (is_uncond || pred_taken);
        bad_tgt  = checked && (calc_tgt != pred_tgt);
        bad_ctrl = valid && pred_taken && !is_ctrl;
    end
endmodule

// File: rtl/brc_first_pick.sv
// Priority pick of the lowest-index request. Returns the one-hot winner and
// a mask covering every position up to and including the winner (all ones
// when nothing requests).
module brc_first_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] first_oh,
    output logic [N-1:0] upto,
    output logic         any
);
    // Walk the slots in order, tracking whether a winner was seen.
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < N; i++) begin
            first_oh[i] = req[i] && !seen;
            upto[i]     = !seen;
            seen        = seen || req[i];
        end
    end

    assign any = |req;
endmodule

// File: rtl/brc_sat_ctr.sv
// Saturating event counter: adds an increment each cycle and sticks at the
// all-ones value. Synchronous active-low reset.
module brc_sat_ctr #(
    parameter int W     = 8,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     count
);
    localparam int          SUM_W = ((W > INC_W) ? W : INC_W) + 1;
    localparam logic [W-1:0] MAX  = '1;

    logic [SUM_W-1:0] sum;

    // Wide sum so an overflow can be seen before it wraps.
    assign sum = SUM_W'(count) + SUM_W'(inc);

    // Register the saturated sum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (sum > SUM_W'(MAX))
            count <= MAX;
        else
            count <= sum[W-1:0];
    end

    // R10/R11: a counter at its maximum never wraps back down.
    assert_sat_hold_R10_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAX) |=> (count == MAX));
    // R10/R11: the count never decreases outside reset.
    assert_no_decrease_R10_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (count >= $past(count)));
endmodule

// File: rtl/br_target_check.sv
// Decode-time branch target checker. Evaluates SLOTS instructions given in
// program order, picks the first wrong prediction as the squash point,
// forwards slots up to it, flags younger slots as killed and registers a
// redirect record valid for one cycle. Counts resolved branches and target
// mispredictions with saturating counters.
// Assumes computed targets and branching status arrive with each slot.
module br_target_check
    import brc_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SLOTS-1:0]       slot_valid,
    input  logic [SLOTS*SEQ_W-1:0] slot_seq,
    input  logic [SLOTS-1:0]       slot_ctrl,
    input  logic [SLOTS-1:0]       slot_direct,
    input  logic [SLOTS-1:0]       slot_uncond,
    input  logic [SLOTS-1:0]       slot_pred_taken,
    input  logic [SLOTS-1:0]       slot_branching,
    input  logic [SLOTS-1:0]       slot_no_src,
    input  logic [SLOTS*PC_W-1:0]  slot_pred_tgt,
    input  logic [SLOTS*PC_W-1:0]  slot_calc_tgt,
    output logic [SLOTS-1:0]       fwd_valid,
    output logic [SLOTS-1:0]       fwd_can_issue,
    output logic [SLOTS-1:0]       slot_kill,
    output logic                   redir_valid,
    output logic                   redir_squash,
    output logic                   redir_mispred,
    output logic [SEQ_W-1:0]       redir_seq,
    output logic [PC_W-1:0]        redir_pc,
    output logic                   redir_taken,
    output logic                   pred_fault,
    output logic [CNT_W-1:0]       cnt_resolved,
    output logic [CNT_W-1:0]       cnt_mispred
);
    localparam int INC_W = $clog2(SLOTS + 1);

    logic [SLOTS-1:0] checked, bad_tgt, bad_ctrl, stop;
    logic [SLOTS-1:0] hit_oh, upto;
    logic             any_hit;
    logic [SEQ_W-1:0] off_seq;
    logic [PC_W-1:0]  off_pc;
    logic             off_taken, off_mis, off_fault;
    logic [INC_W-1:0] res_inc, mis_inc;
    redir_flags_t     flags_q;

    // One evaluator per slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        brc_slot_eval #(.PC_W(PC_W)) u_eval (
            .valid      (slot_valid[g]),
            .is_ctrl    (slot_ctrl[g]),
            .is_direct  (slot_direct[g]),
            .is_uncond  (slot_uncond[g]),
            .pred_taken (slot_pred_taken[g]),
            .pred_tgt   (slot_pred_tgt[g*PC_W +: PC_W]),
            .calc_tgt   (slot_calc_tgt[g*PC_W +: PC_W]),
            .checked    (checked[g]),
            .bad_tgt    (bad_tgt[g]),
            .bad_ctrl   (bad_ctrl[g])
        );
    end

    assign stop = bad_tgt | bad_ctrl;

    brc_first_pick #(.N(SLOTS)) u_pick (
        .req      (stop),
        .first_oh (hit_oh),
        .upto     (upto),
        .any      (any_hit)
    );

    // Select the squash point's fields through the one-hot winner.
    always_comb begin
        off_seq   = '0;
        off_pc    = '0;
        off_taken = 1'b0;
        off_mis   = 1'b0;
        off_fault = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (hit_oh[i]) begin
                off_seq   = slot_seq[i*SEQ_W +: SEQ_W];
                off_pc    = slot_calc_tgt[i*PC_W +: PC_W];
                off_taken = slot_branching[i] || slot_uncond[i];
                off_mis   = bad_tgt[i];
                off_fault = bad_ctrl[i];
            end
        end
    end

    // Per-slot outputs toward the next stage.
    always_comb begin
        fwd_valid     = slot_valid & upto;
        fwd_can_issue = fwd_valid & slot_no_src;
        for (int i = 0; i < SLOTS; i++)
            slot_kill[i] = any_hit && slot_valid[i] &&
                           (slot_seq[i*SEQ_W +: SEQ_W] > off_seq);
    end

    // Register the redirect record; cleared when no squash point exists.
    always_ff @(posedge clk) begin
        if (!rst_n || !any_hit) begin
            flags_q   <= '0;
            redir_seq <= '0;
            redir_pc  <= '0;
        end else begin
            flags_q   <= '{valid: 1'b1, mispred: off_mis, taken: off_taken, fault: off_fault};
            redir_seq <= off_seq;
            redir_pc  <= off_pc;
        end
    end

    assign redir_valid   = flags_q.valid;
    assign redir_squash  = flags_q.valid;
    assign redir_mispred = flags_q.mispred;
    assign redir_taken   = flags_q.taken;
    assign pred_fault    = flags_q.fault;

    // Counter increments for this cycle.
    assign res_inc = INC_W'($countones(checked & upto));
    assign mis_inc = INC_W'(off_mis);

    brc_sat_ctr #(.W(CNT_W), .INC_W(INC_W)) u_cnt_res (
        .clk (clk), .rst_n (rst_n), .inc (res_inc), .count (cnt_resolved)
    );
    brc_sat_ctr #(.W(CNT_W), .INC_W(INC_W)) u_cnt_mis (
        .clk (clk), .rst_n (rst_n), .inc (mis_inc), .count (cnt_mispred)
    );

    // R8: at most one squash point per group.
    assert_one_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_oh));
    // R5: a killed slot is never forwarded.
    assert_kill_not_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_kill & fwd_valid) == '0);
    // R7: issue readiness only on forwarded slots.
    assert_issue_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_can_issue & ~fwd_valid) == '0);
    // R6: a redirect is either a target mismatch or a fault, never both.
    assert_redir_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (redir_mispred ^ pred_fault));
    // R9: redirect follows an offending group by one cycle.
    assert_redir_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |=> redir_valid);
    // R9: a quiet redirect carries no payload.
    assert_quiet_payload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !redir_valid |-> (redir_seq == '0 && redir_pc == '0 && !pred_fault));
endmodule

// File: tb/br_target_check_tb.sv
`timescale 1ns/1ps
module br_target_check_tb_top;
    localparam int SLOTS = 4, SEQ_W = 16, PC_W = 32, CNT_W = 3;
    localparam int MAXC = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [SLOTS-1:0] v, ctl, dir, unc, pt, brn, nsrc;
    logic [SEQ_W-1:0] seq [SLOTS];
    logic [PC_W-1:0]  ptg [SLOTS];
    logic [PC_W-1:0]  ctg [SLOTS];
    logic [SLOTS*SEQ_W-1:0] seq_f;
    logic [SLOTS*PC_W-1:0]  ptg_f, ctg_f;

    for (genvar g = 0; g < SLOTS; g++) begin : g_pack
        assign seq_f[g*SEQ_W +: SEQ_W] = seq[g];
        assign ptg_f[g*PC_W +: PC_W]   = ptg[g];
        assign ctg_f[g*PC_W +: PC_W]   = ctg[g];
    end

    logic [SLOTS-1:0] fwd, iss, kill;
    logic rv, rsq, rmis, rtk, rflt;
    logic [SEQ_W-1:0] rseq;
    logic [PC_W-1:0]  rpc;
    logic [CNT_W-1:0] cres, cmis;

    br_target_check #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .slot_valid(v), .slot_seq(seq_f), .slot_ctrl(ctl),
        .slot_direct(dir), .slot_uncond(unc), .slot_pred_taken(pt), .slot_branching(brn),
        .slot_no_src(nsrc), .slot_pred_tgt(ptg_f), .slot_calc_tgt(ctg_f),
        .fwd_valid(fwd), .fwd_can_issue(iss), .slot_kill(kill), .redir_valid(rv),
        .redir_squash(rsq), .redir_mispred(rmis), .redir_seq(rseq), .redir_pc(rpc),
        .redir_taken(rtk), .pred_fault(rflt), .cnt_resolved(cres), .cnt_mispred(cmis));

    int checks = 0, errors = 0;
    int exp_res = 0, exp_mis = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sat(input int a, input int inc);
        return (a + inc > MAXC) ? MAXC : a + inc;
    endfunction

    task automatic clear_slots();
        v = '0; ctl = '0; dir = '0; unc = '0; pt = '0; brn = '0; nsrc = '0;
        for (int i = 0; i < SLOTS; i++) begin
            seq[i] = SEQ_W'(100 + i); ptg[i] = '0; ctg[i] = '0;
        end
    endtask

    // Place one valid slot.
    task automatic put(input int i, input bit c, input bit d, input bit u, input bit p,
                       input bit b, input bit n, input int pt_tgt, input int c_tgt);
        v[i] = 1'b1; ctl[i] = c; dir[i] = d; unc[i] = u; pt[i] = p; brn[i] = b;
        nsrc[i] = n; ptg[i] = PC_W'(pt_tgt); ctg[i] = PC_W'(c_tgt);
    endtask

    // Apply the current slots for one cycle and check both stages.
    task automatic apply(input string tag, input logic [SLOTS-1:0] e_fwd,
                         input logic [SLOTS-1:0] e_kill, input logic [SLOTS-1:0] e_iss,
                         input bit e_rv, input int e_seq, input int e_pc, input bit e_tk,
                         input bit e_mis, input bit e_flt, input int res_inc, input int mis_inc);
        #1;
        chk(fwd == e_fwd, {tag, " fwd"}, fwd, e_fwd);
        chk(kill == e_kill, {tag, " kill"}, kill, e_kill);
        chk(iss == e_iss, {tag, " can_issue"}, iss, e_iss);
        @(posedge clk); #1;
        exp_res = sat(exp_res, res_inc);
        exp_mis = sat(exp_mis, mis_inc);
        chk(rv == e_rv && rsq == e_rv, {tag, " redir_valid"}, {rv, rsq}, {e_rv, e_rv});
        chk(rseq == SEQ_W'(e_seq) && rpc == PC_W'(e_pc), {tag, " redir seq/pc"},
            {rseq, rpc}, {SEQ_W'(e_seq), PC_W'(e_pc)});
        chk(rtk == e_tk && rmis == e_mis && rflt == e_flt, {tag, " taken/mis/fault"},
            {rtk, rmis, rflt}, {e_tk, e_mis, e_flt});
        chk(cres == CNT_W'(exp_res) && cmis == CNT_W'(exp_mis), {tag, " counters R10 R11"},
            {cres, cmis}, {CNT_W'(exp_res), CNT_W'(exp_mis)});
        @(negedge clk);
    endtask

    // R9: reset state.
    task automatic t_reset();
        chk(rv == 1'b0 && rflt == 1'b0 && rseq == '0 && rpc == '0, "R9 reset redirect",
            {rv, rflt}, 0);
        chk(cres == '0 && cmis == '0, "R10 R11 reset counters", {cres, cmis}, 0);
    endtask

    // R4: all predictions right; everything forwards, no redirect.
    task automatic t_all_good();
        clear_slots();
        put(0, 1, 1, 1, 0, 1, 0, 'h40, 'h40);
        put(1, 0, 0, 0, 0, 0, 1, 0, 0);
        put(2, 1, 1, 0, 1, 1, 0, 'h80, 'h80);
        put(3, 0, 0, 0, 0, 0, 0, 0, 0);
        apply("R4 no offender", 4'b1111, 4'b0000, 4'b0010, 0, 0, 0, 0, 0, 0, 2, 0);
    endtask

    // R2 R3 R5: unconditional mismatch in slot 1, taken forced.
    task automatic t_uncond_miss();
        clear_slots();
        put(0, 0, 0, 0, 0, 0, 0, 0, 0);
        put(1, 1, 1, 1, 0, 0, 0, 'h100, 'h204);
        put(2, 0, 0, 0, 0, 0, 1, 0, 0);
        put(3, 0, 0, 0, 0, 0, 0, 0, 0);
        seq[3] = 16'd50;
        apply("R2 R3 R5 uncond miss", 4'b0011, 4'b0100, 4'b0000, 1, 101, 'h204, 1, 1, 0, 1, 1);
    endtask

    // R3: conditional predicted-taken mismatch, taken follows branching bit.
    task automatic t_cond_miss();
        clear_slots();
        put(0, 1, 1, 0, 1, 0, 1, 'h10, 'h14);
        apply("R3 cond miss not branching", 4'b0001, 4'b0000, 4'b0001, 1, 100, 'h14, 0, 1, 0, 1, 1);
        clear_slots();
        put(0, 1, 1, 0, 1, 1, 0, 'h10, 'h18);
        apply("R3 cond miss branching", 4'b0001, 4'b0000, 4'b0000, 1, 100, 'h18, 1, 1, 0, 1, 1);
    endtask

    // R1: unchecked slots with mismatching targets do not redirect.
    task automatic t_unchecked();
        clear_slots();
        put(0, 1, 1, 0, 0, 0, 0, 'h10, 'h99);
        put(1, 1, 0, 1, 1, 1, 0, 'h20, 'h77);
        apply("R1 unchecked slots", 4'b0011, 4'b0000, 4'b0000, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // R6: predicted-taken non-control instruction.
    task automatic t_fault();
        clear_slots();
        put(0, 0, 0, 0, 0, 0, 1, 0, 0);
        put(1, 0, 0, 0, 0, 0, 0, 0, 0);
        put(2, 0, 0, 0, 1, 0, 1, 'h30, 'h3c);
        put(3, 1, 1, 1, 0, 1, 1, 'h50, 'h60);
        apply("R6 fault", 4'b0111, 4'b1000, 4'b0101, 1, 102, 'h3c, 0, 0, 1, 0, 0);
    endtask

    // R8: two offenders; lowest index wins.
    task automatic t_priority();
        clear_slots();
        put(0, 1, 1, 1, 0, 1, 0, 'h8, 'h8);
        put(1, 1, 1, 0, 1, 1, 0, 'h10, 'h1c);
        put(2, 0, 0, 0, 0, 0, 0, 0, 0);
        put(3, 1, 1, 1, 0, 1, 0, 'h20, 'h2c);
        apply("R8 priority", 4'b0011, 4'b1100, 4'b0000, 1, 101, 'h1c, 1, 1, 0, 2, 1);
    endtask

    // R7 R9: no-source slots ready; redirect gone the cycle after.
    task automatic t_pulse();
        clear_slots();
        put(0, 0, 0, 0, 0, 0, 1, 0, 0);
        put(1, 0, 0, 0, 0, 0, 0, 0, 0);
        put(2, 0, 0, 0, 0, 0, 1, 0, 0);
        apply("R7 R9 quiet after redirect", 4'b0111, 4'b0000, 4'b0101, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // R10 R11: drive counters past their maximum.
    task automatic t_saturate();
        for (int k = 0; k < 3; k++) begin
            clear_slots();
            for (int i = 0; i < SLOTS; i++) put(i, 1, 1, 1, 0, 1, 0, 'h40, 'h40);
            apply("R10 saturate resolved", 4'b1111, 4'b0000, 4'b0000, 0, 0, 0, 0, 0, 0, 4, 0);
        end
        for (int k = 0; k < 8; k++) begin
            clear_slots();
            put(0, 1, 1, 1, 0, 1, 0, 'h40, 'h44);
            apply("R11 saturate mispred", 4'b0001, 4'b0000, 4'b0000, 1, 100, 'h44, 1, 1, 0, 1, 1);
        end
    endtask

    initial begin
        clear_slots();
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_all_good();
        t_uncond_miss();
        t_cond_miss();
        t_unchecked();
        t_fault();
        t_priority();
        t_pulse();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule